// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one channel of a general-purpose timer used as an output compare stage. Each clock it compares an externally supplied counter value with its active compare register and updates a registered reference level according to a 3-bit mode: hold, drive high on equality, drive low on equality, invert on equality, force low, force high, or one of two opposite-polarity PWM levels. The counter itself lives outside the channel.

Software writes the compare value through a write strobe. With preloading off, the value reaches the active compare register on the next edge. With preloading on, it lands in a shadow register and is copied to the active register only when an update pulse arrives, for example on counter wrap. A separate 2-bit direction field marks the channel as an output or as an input taken from its own pin, its paired neighbour's pin or an internal trigger line. While the channel is an input, the reference level is held low.

Top module: `occh_channel`

## Requirements
- R1: After reset `ref_o` is 0, the mode is frozen (code 0), the direction is output (code 0), preloading is off and `active_cmp_o` is 0.
- R2: Mode code 0 (frozen) keeps `ref_o` at its present level, including on cycles where the counter equals the active compare value.
- R3: Mode code 1 sets `ref_o` to 1 on the edge that samples counter == active compare. Mode code 2 clears it to 0 on that edge. On other cycles both modes hold the level.
- R4: Mode code 3 inverts `ref_o` on every edge that samples counter == active compare, and holds it otherwise.
- R5: Mode code 4 drives `ref_o` to 0 and mode code 5 drives it to 1, whatever the comparison gives.
- R6: Mode code 6 makes `ref_o` 1 exactly when the sampled counter is below the active compare value (unsigned).
- R7: Mode code 7 makes `ref_o` 0 exactly when the sampled counter is below the active compare value, and 1 otherwise.
- R8: With preloading off, a compare write appears on `active_cmp_o` after the next edge. The update pulse has no effect in this case.
- R9: With preloading on, a compare write leaves `active_cmp_o` unchanged. An update pulse copies the shadow value into it on the next edge. If a write and an update fall in the same cycle, the update copies the shadow value from before that write.
- R10: Direction code 0 is output. Codes 1, 2 and 3 set `is_input_o` and drive `in_src_o` one-hot: bit 0 for the own pin, bit 1 for the paired pin, bit 2 for the trigger line. While the channel is an input, `ref_o` is 0 and the mode is ignored.
- R11: A configuration write registers on the edge where `cfg_wr_i` is high. `ref_o` follows the new mode from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | W | Counter value from the timer |
| cfg_wr_i | input | 1 | Strobe that loads mode, direction and preload enable |
| cfg_mode_i | input | 3 | Output compare mode code |
| cfg_dir_i | input | 2 | Direction / input source code |
| cfg_preload_i | input | 1 | Compare preload enable |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | W | Compare value to write |
| update_i | input | 1 | Update event pulse |
| ref_o | output | 1 | Registered reference level |
| active_cmp_o | output | W | Active compare register |
| is_input_o | output | 1 | Channel configured as input |
| in_src_o | output | 3 | One-hot input source |

## Verification
The bench sweeps every counter value against every compare value in both PWM modes. An off-by-one in the less-than test would show up at the equality point, and swapped polarities would invert every row of the sweep. For the event modes it holds the counter away from the compare value and then lands on it. A design that treated set, clear or toggle as level-based, or that let the frozen mode react, would change the level on the wrong cycle. Preload tests cover a write that arrives without an update, an update while preloading is off, and a write in the same cycle as an update. A design that bypassed the shadow register or copied the new value would show the wrong `active_cmp_o`. Input-direction tests start from a high reference level, so a design that still honoured the mode would leave it high.

// File: rtl/occh_pkg.sv
package occh_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN   = 3'd0,
    OCM_SET      = 3'd1,
    OCM_CLR      = 3'd2,
    OCM_TOGGLE   = 3'd3,
    OCM_FORCE_LO = 3'd4,
    OCM_FORCE_HI = 3'd5,
    OCM_PWM_A    = 3'd6,
    OCM_PWM_B    = 3'd7
  } ocm_e;

  typedef enum logic [1:0] {
    DIR_OUT      = 2'd0,
    DIR_IN_OWN   = 2'd1,
    DIR_IN_PAIR  = 2'd2,
    DIR_IN_TRIG  = 2'd3
  } dir_e;

  localparam int unsigned N_SRC = 3;

  // Next reference level from mode, equality, below-flag and present level.
  function automatic logic next_ref(ocm_e m, logic eq, logic below, logic cur);
    logic r;
    case (m)
      OCM_FROZEN:   r = cur;
      OCM_SET:      r = eq ? 1'b1 : cur;
      OCM_CLR:      r = eq ? 1'b0 : cur;
      OCM_TOGGLE:   r = eq ? ~cur : cur;
      OCM_FORCE_LO: r = 1'b0;
      OCM_FORCE_HI: r = 1'b1;
      OCM_PWM_A:    r = below;
      default:      r = ~below;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/occh_cmp_regs.sv
module occh_cmp_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         preload_i,
  input  logic         update_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i) shadow_q <= wdata_i;
      if (!preload_i) begin
        if (wr_i) active_q <= wdata_i;
      end else if (update_i) begin
        active_q <= shadow_q;
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/occh_ref_gen.sv
module occh_ref_gen
  import occh_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ocm_e         mode_i,
  input  logic         out_mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         match_o,
  output logic         below_o,
  output logic         ref_o
);
  logic ref_q;
  logic ref_d;

  assign match_o = (cnt_i == cmp_i);
  assign below_o = (cnt_i < cmp_i);

  always_comb begin
    if (out_mode_i) ref_d = next_ref(mode_i, match_o, below_o, ref_q);
    else            ref_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/occh_dir_dec.sv
module occh_dir_dec
  import occh_pkg::*;
(
  input  dir_e             dir_i,
  output logic             is_input_o,
  output logic [N_SRC-1:0] src_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign src_o[i] = (dir_i == dir_e'(i + 1));
  end
  assign is_input_o = (dir_i != DIR_OUT);
endmodule

// File: rtl/occh_channel.sv
module occh_channel
  import occh_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         cfg_wr_i,
  input  logic [2:0]   cfg_mode_i,
  input  logic [1:0]   cfg_dir_i,
  input  logic         cfg_preload_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         update_i,
  output logic         ref_o,
  output logic [W-1:0] active_cmp_o,
  output logic         is_input_o,
  output logic [2:0]   in_src_o
);
  ocm_e   mode_q;
  dir_e   dir_q;
  logic   preload_q;
  logic   out_mode_w;
  logic   match_w;
  logic   below_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= OCM_FROZEN;
      dir_q     <= DIR_OUT;
      preload_q <= 1'b0;
    end else if (cfg_wr_i) begin
      mode_q    <= ocm_e'(cfg_mode_i);
      dir_q     <= dir_e'(cfg_dir_i);
      preload_q <= cfg_preload_i;
    end
  end

  assign out_mode_w = (dir_q == DIR_OUT);

  occh_cmp_regs #(.W(W)) cmp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (cmp_wr_i),
    .wdata_i   (cmp_wdata_i),
    .preload_i (preload_q),
    .update_i  (update_i),
    .active_o  (active_cmp_o)
  );

  occh_ref_gen #(.W(W)) ref_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_q),
    .out_mode_i (out_mode_w),
    .cnt_i      (cnt_i),
    .cmp_i      (active_cmp_o),
    .match_o    (match_w),
    .below_o    (below_w),
    .ref_o      (ref_o)
  );

  occh_dir_dec dir_i (
    .dir_i      (dir_q),
    .is_input_o (is_input_o),
    .src_o      (in_src_o)
  );
endmodule

// File: rtl/occh_chk.sv
module occh_chk
  import occh_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input ocm_e         mode_q,
  input logic         out_mode_w,
  input logic         match_w,
  input logic         preload_q,
  input logic         cmp_wr_i,
  input logic [W-1:0] cmp_wdata_i,
  input logic         update_i,
  input logic         ref_o,
  input logic [W-1:0] active_cmp_o,
  input logic         is_input_o,
  input logic [2:0]   in_src_o
);
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_w && mode_q == OCM_FROZEN) |=> $stable(ref_o)); // R2
  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_w && mode_q == OCM_SET && match_w) |=> ref_o); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_w && mode_q == OCM_TOGGLE && match_w) |=> (ref_o != $past(ref_o))); // R4
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_w && mode_q == OCM_FORCE_LO) |=> !ref_o); // R5
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_q && cmp_wr_i) |=> (active_cmp_o == $past(cmp_wdata_i))); // R8
  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_q && !update_i) |=> $stable(active_cmp_o)); // R9
  AST_INPUT_REF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_mode_w) |=> !ref_o); // R10
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_src_o) && (is_input_o == (in_src_o != 3'b000))); // R10
endmodule

bind occh_channel occh_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_q       (mode_q),
  .out_mode_w   (out_mode_w),
  .match_w      (match_w),
  .preload_q    (preload_q),
  .cmp_wr_i     (cmp_wr_i),
  .cmp_wdata_i  (cmp_wdata_i),
  .update_i     (update_i),
  .ref_o        (ref_o),
  .active_cmp_o (active_cmp_o),
  .is_input_o   (is_input_o),
  .in_src_o     (in_src_o)
);

// File: tb/occh_channel_tb_top.sv
module occh_channel_tb_top;
  localparam int unsigned W = 4;
  localparam int unsigned NV = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_i = '0;
  logic         cfg_wr_i = 1'b0;
  logic [2:0]   cfg_mode_i = '0;
  logic [1:0]   cfg_dir_i = '0;
  logic         cfg_preload_i = 1'b0;
  logic         cmp_wr_i = 1'b0;
  logic [W-1:0] cmp_wdata_i = '0;
  logic         update_i = 1'b0;
  logic         ref_o;
  logic [W-1:0] active_cmp_o;
  logic         is_input_o;
  logic [2:0]   in_src_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  occh_channel #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cfg_wr_i(cfg_wr_i),
    .cfg_mode_i(cfg_mode_i), .cfg_dir_i(cfg_dir_i), .cfg_preload_i(cfg_preload_i),
    .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i), .update_i(update_i),
    .ref_o(ref_o), .active_cmp_o(active_cmp_o), .is_input_o(is_input_o),
    .in_src_o(in_src_o)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One edge; inputs were set away from the edge, outputs sampled 2 ns after it.
  task automatic step();
    @(posedge clk);
    #2;
    cfg_wr_i = 1'b0;
    cmp_wr_i = 1'b0;
    update_i = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] m, input logic [1:0] d, input logic p);
    cfg_wr_i = 1'b1; cfg_mode_i = m; cfg_dir_i = d; cfg_preload_i = p;
    step();
  endtask

  task automatic wr_cmp(input logic [W-1:0] v);
    cmp_wr_i = 1'b1; cmp_wdata_i = v;
    step();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    done = 1'b1;
  end

  initial begin : main
    logic exp_ref;
    #25;
    check(ref_o, 0, "R1 ref after reset");
    check(active_cmp_o, 0, "R1 active after reset");
    check(is_input_o, 0, "R1 direction after reset");
    rst_n = 1'b1;
    cnt_i = 4'd0;
    step();
    check(ref_o, 0, "R1 frozen default with cnt==cmp");

    // R6 / R7 exhaustive sweep
    for (int m = 6; m <= 7; m++) begin
      cfg(3'(m), 2'd0, 1'b0);
      for (int c = 0; c < int'(NV); c++) begin
        wr_cmp(W'(c));
        for (int k = 0; k < int'(NV); k++) begin
          cnt_i = W'(k);
          step();
          exp_ref = (k < c) ? 1'b1 : 1'b0;
          if (m == 7) exp_ref = ~exp_ref;
          check(ref_o, exp_ref, (m == 6) ? "R6 pwm low-active sweep" : "R7 pwm inverted sweep");
        end
      end
    end

    // R3 set / clear on match
    wr_cmp(4'd5);
    cfg(3'd4, 2'd0, 1'b0); step();
    check(ref_o, 0, "R5 force low");
    cfg(3'd1, 2'd0, 1'b0);
    cnt_i = 4'd2; step();
    check(ref_o, 0, "R3 set mode no match");
    cnt_i = 4'd5; step();
    check(ref_o, 1, "R3 set on match");
    cnt_i = 4'd6; step();
    check(ref_o, 1, "R3 set holds after match");
    cfg(3'd2, 2'd0, 1'b0);
    cnt_i = 4'd1; step();
    check(ref_o, 1, "R3 clear mode no match");
    cnt_i = 4'd5; step();
    check(ref_o, 0, "R3 clear on match");

    // R4 toggle
    cfg(3'd3, 2'd0, 1'b0);
    exp_ref = 1'b0;
    for (int t = 0; t < 4; t++) begin
      cnt_i = 4'd5; step(); exp_ref = ~exp_ref;
      check(ref_o, exp_ref, "R4 toggle on match");
      cnt_i = 4'd9; step();
      check(ref_o, exp_ref, "R4 toggle holds off match");
    end

    // R11 / R5 mode change timing, force high
    cfg(3'd4, 2'd0, 1'b0); step();
    check(ref_o, 0, "R5 force low again");
    cfg(3'd5, 2'd0, 1'b0);
    check(ref_o, 0, "R11 old mode on write edge");
    step();
    check(ref_o, 1, "R11 R5 force high next edge");

    // R2 frozen keeps high across a match
    cfg(3'd0, 2'd0, 1'b0);
    cnt_i = 4'd5; step(); step();
    check(ref_o, 1, "R2 frozen ignores match");
    cnt_i = 4'd0; step();
    check(ref_o, 1, "R2 frozen ignores below");

    // R8 direct write, update without effect
    wr_cmp(4'd11);
    check(active_cmp_o, 11, "R8 direct write");
    update_i = 1'b1; step();
    check(active_cmp_o, 11, "R8 update ignored when direct");

    // R9 preload
    cfg(3'd0, 2'd0, 1'b1);
    wr_cmp(4'd3);
    check(active_cmp_o, 11, "R9 write held in shadow");
    step();
    check(active_cmp_o, 11, "R9 still held");
    update_i = 1'b1; step();
    check(active_cmp_o, 3, "R9 update copies shadow");
    cmp_wr_i = 1'b1; cmp_wdata_i = 4'd12; update_i = 1'b1; step();
    check(active_cmp_o, 3, "R9 same-cycle update uses old shadow");
    update_i = 1'b1; step();
    check(active_cmp_o, 12, "R9 later update copies new shadow");

    // R10 input directions
    cfg(3'd5, 2'd0, 1'b0); step();
    check(ref_o, 1, "R10 prep high");
    for (int d = 1; d <= 3; d++) begin
      cfg(3'd5, 2'(d), 1'b0); step();
      check(ref_o, 0, "R10 input forces ref low");
      check(is_input_o, 1, "R10 input flag");
      check(in_src_o, 32'(1 << (d - 1)), "R10 input source one-hot");
    end
    cfg(3'd5, 2'd0, 1'b0);
    check(is_input_o, 0, "R10 back to output");
    check(in_src_o, 0, "R10 no source as output");
    step();
    check(ref_o, 1, "R10 mode applies again as output");

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule